// File: doc/BRIEF.md
# Microinstruction Sequencer with Counted Loops

This block runs a stored program for a neural arithmetic unit in hardware, so that no processor has to generate the microinstructions. A host fills a small program memory through a write port while the block is idle, then pulses a start input. From address zero the block steps through the program one word per clock.

Each executable word produces a 37-bit microinstruction together with a one-cycle issue strobe. The target unit uses that strobe as its clock enable. The value on the data input is captured in the same cycle, so a data word travels with its instruction. Counted loop words and the stop word are handled inside the sequencer and never reach the target. Loops nest up to four deep. A loop count of zero skips its whole body, including any loops nested inside it.

Top module: `useq_top`

## Requirements
- R1: During and after reset, before any start, busy_o, issue_o and uinstr_o are all low.
- R2: A start_i pulse seen while idle sets busy_o in the next cycle and begins execution at address 0. A start_i pulse seen while busy is ignored and does not restart the program.
- R3: A program word whose opcode field bits [39:37] equal 0 (execute) produces issue_o high for exactly one cycle, with uinstr_o equal to word bits [36:0]. This happens one cycle after the word is fetched, and words are issued in address order.
- R4: On each issue, data_o takes the value data_i held in the cycle before the strobe. data_o does not change in any cycle without issue.
- R5: Opcode 1 (repeat), with the count n>=1 in bits [7:0], runs the body up to the matching opcode 2 (end-repeat) exactly n times. Counts up to 255 are supported.
- R6: Loops nest up to 4 deep. Each level keeps its own count and return address.
- R7: A repeat with count 0 skips forward past its matching end-repeat. Nothing inside the skipped region is issued, including nested loops.
- R8: Repeat and end-repeat words never raise issue_o. The number of strobes equals the number of executed opcode-0 words.
- R9: Opcode 3 (stop) drops busy_o in the cycle after it is fetched. No strobe occurs while idle.
- R10: Program-memory writes presented while busy_o is high are ignored.
- R11: Opcodes 4 to 7 are passed over without a strobe, and execution continues with the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_en_i | input | 1 | Program-memory write enable |
| load_addr_i | input | 5 | Program-memory write address |
| load_word_i | input | 40 | Program word: opcode [39:37], payload [36:0] |
| start_i | input | 1 | Begin execution at address 0 |
| data_i | input | 12 | Data word captured alongside each issue |
| busy_o | output | 1 | Program running |
| issue_o | output | 1 | One-cycle issue strobe and target clock enable |
| uinstr_o | output | 37 | Issued microinstruction |
| data_o | output | 12 | Data captured with the latest issue |

## Verification
The issue of a microinstruction and the capture of its data word happen in the same cycle. The bench therefore changes data_i on every clock, so each strobe has a distinct value to carry. At every falling edge it compares data_o with the data_i of the cycle just closed when the strobe is high, and with its previous value when the strobe is low. The bench also drives a start pulse and a program write into the middle of a running loop. It then judges that neither one moves execution, by checking the strobe count of that run and the contents of the next run.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int UINSTR_W = 37;
  localparam int OP_W     = 3;
  localparam int WORD_W   = OP_W + UINSTR_W;
  localparam int CNT_W    = 8;

  typedef enum logic [OP_W-1:0] {
    OP_EXEC   = 3'd0,
    OP_REPEAT = 3'd1,
    OP_ENDREP = 3'd2,
    OP_STOP   = 3'd3
  } op_e;
endpackage

// File: rtl/useq_prog_mem.sv
module useq_prog_mem #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 40,
  parameter int AW    = 5
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/useq_loop_stack.sv
module useq_loop_stack #(
  parameter int DEPTH = 4,
  parameter int AW    = 5,
  parameter int CW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [CW-1:0] push_cnt_i,
  input  logic          pop_i,
  input  logic          dec_i,
  output logic [AW-1:0] top_addr_o,
  output logic [CW-1:0] top_cnt_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [LW-1:0] lvl_q;
  logic [AW-1:0] addr_q [DEPTH];
  logic [CW-1:0] cnt_q  [DEPTH];
  logic [IW-1:0] top_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lvl_q <= '0;
    else if (clr_i)  lvl_q <= '0;
    else if (push_i) lvl_q <= lvl_q + LW'(1);
    else if (pop_i)  lvl_q <= lvl_q - LW'(1);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_q[g] <= '0;
        cnt_q[g]  <= '0;
      end else if (push_i && lvl_q == LW'(g)) begin
        addr_q[g] <= push_addr_i;
        cnt_q[g]  <= push_cnt_i;
      end else if (dec_i && lvl_q == LW'(g + 1)) begin
        cnt_q[g]  <= cnt_q[g] - CW'(1);
      end
    end
  end

  assign top_idx    = IW'(lvl_q - LW'(1));
  assign empty_o    = (lvl_q == '0);
  assign full_o     = (lvl_q == LW'(DEPTH));
  assign top_addr_o = empty_o ? '0 : addr_q[top_idx];
  assign top_cnt_o  = empty_o ? '0 : cnt_q[top_idx];

  // nesting limit
  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // end-repeat only against an open loop
  assert_no_underflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i || dec_i) |-> !empty_o);
  assert_push_pop_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && (pop_i || dec_i)));
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int PROG_DEPTH = 32,
  parameter int LOOP_DEPTH = 4,
  parameter int DATA_W     = 12,
  localparam int AW        = $clog2(PROG_DEPTH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_en_i,
  input  logic [AW-1:0]       load_addr_i,
  input  logic [WORD_W-1:0]   load_word_i,
  input  logic                start_i,
  input  logic [DATA_W-1:0]   data_i,
  output logic                busy_o,
  output logic                issue_o,
  output logic [UINSTR_W-1:0] uinstr_o,
  output logic [DATA_W-1:0]   data_o
);
  localparam int SKW = AW + 1;

  logic                busy_q, busy_d;
  logic [AW-1:0]       pc_q, pc_d;
  logic                issue_q, issue_d;
  logic [UINSTR_W-1:0] uinstr_q;
  logic [DATA_W-1:0]   data_q;
  logic                skip_q, skip_d;
  logic [SKW-1:0]      skip_lvl_q, skip_lvl_d;

  logic [WORD_W-1:0]   word;
  op_e                 op;
  logic [UINSTR_W-1:0] payload;
  logic [CNT_W-1:0]    rep_n;

  logic                st_clr, st_push, st_pop, st_dec, st_empty, st_full;
  logic [AW-1:0]       st_addr;
  logic [CNT_W-1:0]    st_cnt;

  useq_prog_mem #(.DEPTH(PROG_DEPTH), .WIDTH(WORD_W), .AW(AW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (load_en_i && !busy_q),
    .waddr_i (load_addr_i),
    .wdata_i (load_word_i),
    .raddr_i (pc_q),
    .rdata_o (word)
  );

  useq_loop_stack #(.DEPTH(LOOP_DEPTH), .AW(AW), .CW(CNT_W)) u_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (st_clr),
    .push_i      (st_push),
    .push_addr_i (pc_q + AW'(1)),
    .push_cnt_i  (rep_n),
    .pop_i       (st_pop),
    .dec_i       (st_dec),
    .top_addr_o  (st_addr),
    .top_cnt_o   (st_cnt),
    .empty_o     (st_empty),
    .full_o      (st_full)
  );

  assign op      = op_e'(word[WORD_W-1 -: OP_W]);
  assign payload = word[UINSTR_W-1:0];
  assign rep_n   = payload[CNT_W-1:0];

  always_comb begin
    busy_d     = busy_q;
    pc_d       = pc_q;
    issue_d    = 1'b0;
    skip_d     = skip_q;
    skip_lvl_d = skip_lvl_q;
    st_clr     = 1'b0;
    st_push    = 1'b0;
    st_pop     = 1'b0;
    st_dec     = 1'b0;
    if (!busy_q) begin
      if (start_i) begin
        busy_d     = 1'b1;
        pc_d       = '0;
        skip_d     = 1'b0;
        skip_lvl_d = '0;
        st_clr     = 1'b1;
      end
    end else if (skip_q) begin
      // scan forward to the matching end-repeat
      pc_d = pc_q + AW'(1);
      if (op == OP_REPEAT) begin
        skip_lvl_d = skip_lvl_q + SKW'(1);
      end else if (op == OP_ENDREP) begin
        if (skip_lvl_q == '0) skip_d = 1'b0;
        else                  skip_lvl_d = skip_lvl_q - SKW'(1);
      end
    end else begin
      case (op)
        OP_EXEC: begin
          issue_d = 1'b1;
          pc_d    = pc_q + AW'(1);
        end
        OP_REPEAT: begin
          pc_d = pc_q + AW'(1);
          if (rep_n == '0) begin
            skip_d     = 1'b1;
            skip_lvl_d = '0;
          end else begin
            st_push = 1'b1;
          end
        end
        OP_ENDREP: begin
          if (st_empty) begin
            pc_d = pc_q + AW'(1);
          end else if (st_cnt > CNT_W'(1)) begin
            st_dec = 1'b1;
            pc_d   = st_addr;
          end else begin
            st_pop = 1'b1;
            pc_d   = pc_q + AW'(1);
          end
        end
        OP_STOP: busy_d = 1'b0;
        default: pc_d = pc_q + AW'(1);
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      pc_q       <= '0;
      issue_q    <= 1'b0;
      uinstr_q   <= '0;
      data_q     <= '0;
      skip_q     <= 1'b0;
      skip_lvl_q <= '0;
    end else begin
      busy_q     <= busy_d;
      pc_q       <= pc_d;
      issue_q    <= issue_d;
      skip_q     <= skip_d;
      skip_lvl_q <= skip_lvl_d;
      if (issue_d) begin
        uinstr_q <= payload;
        data_q   <= data_i;
      end
    end
  end

  assign busy_o   = busy_q;
  assign issue_o  = issue_q;
  assign uinstr_o = uinstr_q;
  assign data_o   = data_q;

  assert_idle_no_issue_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |=> !issue_o);
  assert_data_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_o |-> $stable(data_o));
  assert_skip_silent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_q |=> !issue_o);
  assert_stop_clears_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !skip_q && op == OP_STOP) |=> !busy_o);
endmodule

// File: tb/tb_useq_top.sv
module tb_useq_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_en_i = 1'b0;
  logic [4:0]  load_addr_i = '0;
  logic [39:0] load_word_i = '0;
  logic        start_i = 1'b0;
  logic [11:0] data_i = '0;
  logic        busy_o, issue_o;
  logic [36:0] uinstr_o;
  logic [11:0] data_o;

  useq_top dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_en_i(load_en_i), .load_addr_i(load_addr_i),
    .load_word_i(load_word_i), .start_i(start_i), .data_i(data_i),
    .busy_o(busy_o), .issue_o(issue_o), .uinstr_o(uinstr_o), .data_o(data_o)
  );

  always #2 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0, n_log = 0, data_err = 0, cyc_total = 0;
  logic [36:0] log_u [600];
  logic [11:0] prev_data = '0;
  logic [39:0] prog [32];
  int poke_start = -1, poke_load = -1;

  localparam int VEC_N   [6] = '{1, 2, 3, 5, 17, 255};
  localparam int VEC_EXP [6] = '{2, 4, 6, 10, 34, 510};
  localparam logic [36:0] PA = 37'h0_1234_5678;
  localparam logic [36:0] PB = 37'h1_0ABC_DEF0;

  function automatic logic [39:0] w_exec(input logic [36:0] p); return {3'd0, p}; endfunction
  function automatic logic [39:0] w_rep(input int n); return {3'd1, 29'd0, n[7:0]}; endfunction
  function automatic logic [39:0] w_end(); return {3'd2, 37'd0}; endfunction
  function automatic logic [39:0] w_stop(); return {3'd3, 37'd0}; endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // issue logger and data pairing monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (issue_o) begin
        if (n_log < 600) log_u[n_log] = uinstr_o;
        n_log++;
        if (data_o !== data_i) data_err++;
      end else if (data_o !== prev_data) data_err++;
      prev_data = data_o;
    end
    data_i = data_i + 12'd1;
  end

  always @(posedge clk_i) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc_total, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic load_all(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      load_en_i = 1'b1; load_addr_i = i[4:0]; load_word_i = prog[i];
    end
    @(negedge clk_i);
    load_en_i = 1'b0;
  endtask

  task automatic run();
    int cyc = 0;
    n_log = 0;
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    while (busy_o && cyc < 5000) begin
      if (cyc == poke_start) start_i = 1'b1;
      if (cyc == poke_load) begin
        load_en_i = 1'b1; load_addr_i = 5'd1; load_word_i = w_exec(37'h55);
      end
      @(negedge clk_i);
      start_i = 1'b0; load_en_i = 1'b0;
      cyc++;
    end
    poke_start = -1; poke_load = -1;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic table_prog(input int n);
    prog[0] = w_rep(n); prog[1] = w_exec(PA); prog[2] = w_exec(PB);
    prog[3] = w_end();  prog[4] = w_stop();
    load_all(5);
  endtask

  initial begin
    bit ok;
    logic [36:0] exp_seq [10];
    repeat (3) @(negedge clk_i);
    chk(busy_o === 1'b0 && issue_o === 1'b0 && uinstr_o === '0, "R1 reset", {busy_o, issue_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(busy_o === 1'b0 && issue_o === 1'b0, "R1 after reset", {busy_o, issue_o}, 0);

    // vector table: loop counts and expected strobe counts
    for (int v = 0; v < 6; v++) begin
      table_prog(VEC_N[v]);
      run();
      chk(n_log == VEC_EXP[v], "R5/R8 loop strobe count", n_log, VEC_EXP[v]);
      ok = 1;
      for (int i = 0; i < n_log && i < 600; i++)
        if (log_u[i] !== ((i % 2 == 0) ? PA : PB)) ok = 0;
      chk(ok, "R3 issue order and payload", ok, 1);
    end

    // exact timing of start, issue and stop
    prog[0] = w_exec(37'h1ABCDE); prog[1] = w_stop();
    load_all(2);
    n_log = 0;
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    chk(busy_o === 1'b1 && issue_o === 1'b0, "R2 busy after start", {busy_o, issue_o}, 2);
    @(negedge clk_i);
    chk(issue_o === 1'b1 && uinstr_o === 37'h1ABCDE, "R3 issue cycle", uinstr_o, 37'h1ABCDE);
    @(negedge clk_i);
    chk(busy_o === 1'b0 && issue_o === 1'b0, "R9 busy falls after stop", {busy_o, issue_o}, 0);
    repeat (5) @(negedge clk_i);
    chk(n_log == 1 && issue_o === 1'b0, "R9 no issue while idle", n_log, 1);

    // two-level nesting sequence
    prog[0] = w_rep(2); prog[1] = w_exec(37'd1); prog[2] = w_rep(3);
    prog[3] = w_exec(37'd2); prog[4] = w_end(); prog[5] = w_exec(37'd3);
    prog[6] = w_end(); prog[7] = w_stop();
    load_all(8);
    run();
    exp_seq = '{37'd1, 37'd2, 37'd2, 37'd2, 37'd3, 37'd1, 37'd2, 37'd2, 37'd2, 37'd3};
    ok = (n_log == 10);
    for (int i = 0; i < 10; i++) if (log_u[i] !== exp_seq[i]) ok = 0;
    chk(ok, "R6 nested sequence", n_log, 10);

    // four-deep nesting
    prog[0] = w_rep(2); prog[1] = w_rep(2); prog[2] = w_rep(2); prog[3] = w_rep(2);
    prog[4] = w_exec(37'd7); prog[5] = w_end(); prog[6] = w_end(); prog[7] = w_end();
    prog[8] = w_end(); prog[9] = w_stop();
    load_all(10);
    run();
    chk(n_log == 16, "R6 four-deep count", n_log, 16);

    // zero-count loop skips nested body
    prog[0] = w_exec(37'd1); prog[1] = w_rep(0); prog[2] = w_exec(37'd9);
    prog[3] = w_rep(3); prog[4] = w_exec(37'd9); prog[5] = w_end(); prog[6] = w_end();
    prog[7] = w_exec(37'd2); prog[8] = w_stop();
    load_all(9);
    run();
    chk(n_log == 2 && log_u[0] === 37'd1 && log_u[1] === 37'd2, "R7 zero count skip", n_log, 2);

    // unused opcodes pass silently
    prog[0] = w_exec(37'd1); prog[1] = {3'd5, 37'd9}; prog[2] = {3'd7, 37'd9};
    prog[3] = w_exec(37'd2); prog[4] = w_stop();
    load_all(5);
    run();
    chk(n_log == 2 && log_u[1] === 37'd2, "R11 unused opcode", n_log, 2);

    // start while busy is ignored
    table_prog(5);
    poke_start = 6;
    run();
    chk(n_log == 10, "R2 start while busy ignored", n_log, 10);

    // load while busy is ignored
    table_prog(3);
    poke_load = 3;
    run();
    chk(n_log == 6, "R10 run with load attempt", n_log, 6);
    run();
    chk(n_log == 6 && log_u[0] === PA && log_u[1] === PB, "R10 program unchanged", log_u[0], PA);

    chk(data_err == 0, "R4 data paired with issue", data_err, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule